// File: doc/BRIEF.md
# Synchronous USB-FIFO Echo Controller

This block sits next to an external USB-to-parallel-FIFO bridge that runs in synchronous mode. All of its logic runs on the clock that the bridge supplies, nominally 60 MHz. The two parts share one 8-bit data path. The block reads every byte the host sends and puts it in a small holding buffer. Whenever the bridge can accept data, the block sends those bytes back in the same order, so the host receives an exact echo of its stream.

The bidirectional pad is not inside the block. The block gives the chip-level pad the byte to transmit (`data_o`) and the enable for the block's own bus driver (`data_drive`). The pad gives the block the value it sees on the pins (`data_i`). The block also sets the bridge's output enable, so it controls which side drives the bus in every cycle. It always leaves one cycle with no driver when the bus changes direction.

Top module: `usb_fifo_echo`

## Requirements
- R1: While reset is asserted and right after it is released, `rd_n`, `wr_n` and `oe_n` are high and `data_drive` is low. The buffer starts empty, so `wr_n` stays high even when `tx_ready_n` is low and the bus is idle.
- R2: `rd_n` is low only while `oe_n` is low. Every read burst begins with at least one cycle in which `oe_n` is low and `rd_n` is still high.
- R3: A byte is taken from `data_i` at every rising clock edge where `rd_n` and `rx_ready_n` are both low. Reading continues, one byte per clock, until `rx_ready_n` goes high or the buffer fills.
- R4: A byte is handed to the bridge at every rising clock edge where `wr_n` and `tx_ready_n` are both low. The byte on `data_o` is always the oldest byte still in the buffer.
- R5: If `tx_ready_n` is high at an edge where `wr_n` is low, that byte is not consumed. `data_o` keeps the same value until the byte is written.
- R6: `data_drive` is never high while `oe_n` is low. `data_drive` rises only after a cycle with `oe_n` high. `oe_n` falls only after a cycle with `data_drive` low.
- R7: The buffer holds 16 bytes. With the write side stalled, exactly 16 bytes are read. After that, `rd_n` and `oe_n` stay high even though `rx_ready_n` is still low.
- R8: `wr_n` is low only while the buffer holds at least one byte.
- R9: When the block is idle and both a read (`rx_ready_n` low, buffer not full) and a write (`tx_ready_n` low, buffer not empty) are possible, the read starts first: `oe_n` goes low and `wr_n` stays high.
- R10: Bytes are echoed in exactly the order they were read, with no byte lost or repeated, whatever the gaps on either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock supplied by the bridge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_ready_n | input | 1 | Low when the bridge has at least one byte to read |
| tx_ready_n | input | 1 | Low when the bridge can accept a byte |
| data_i | input | 8 | Value seen on the shared data pins |
| data_o | output | 8 | Byte the block puts on the pins during writes |
| data_drive | output | 1 | High to enable the block's pad driver |
| oe_n | output | 1 | Active-low enable for the bridge's bus driver |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Two situations are hard to reach from the ports. The first is a full buffer while the bridge still holds bytes. The bench gets there by holding `tx_ready_n` high while it offers more than 16 bytes, then checks that reading stops at exactly 16. The second is the idle cycle in which both a read and a write are possible. The bench first parks bytes in the buffer with writes stalled, then in the same cycle offers new bytes and releases the write side. Rhythmic stall masks on both flags then make the block stall partway through a burst and retry the held byte many times.

// File: rtl/usbfe_pkg.sv
package usbfe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_PRE   = 2'd1,
    ST_RD_BURST = 2'd2,
    ST_WR       = 2'd3
  } usbfe_state_e;

endpackage

// File: rtl/usbfe_buffer.sv
module usbfe_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [DW-1:0]              din,
  output logic [DW-1:0]              dout,
  output logic                       full,
  output logic                       empty,
  output logic                       last_free,
  output logic                       last_item,
  output logic [$clog2(DEPTH):0]     level
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;
  logic          level_en;

  // storage: written only on push, no reset needed
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= din;
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q + AW'(1);
    rd_ptr_d = rd_ptr_q + AW'(1);
    level_en = push ^ pop;
    if (push) begin
      level_d = level_q + LW'(1);
    end else begin
      level_d = level_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push)     wr_ptr_q <= wr_ptr_d;
      if (pop)      rd_ptr_q <= rd_ptr_d;
      if (level_en) level_q  <= level_d;
    end
  end

  assign dout      = mem[rd_ptr_q];
  assign level     = level_q;
  assign full      = (level_q == LW'(DEPTH));
  assign empty     = (level_q == '0);
  assign last_free = (level_q == LW'(DEPTH - 1));
  assign last_item = (level_q == LW'(1));

endmodule

// File: rtl/usbfe_ctrl.sv
module usbfe_ctrl
  import usbfe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_ready_n,
  input  logic tx_ready_n,
  input  logic full,
  input  logic empty,
  input  logic last_free,
  input  logic last_item,
  output logic rd_n,
  output logic wr_n,
  output logic oe_n,
  output logic drive,
  output logic push,
  output logic pop
);

  usbfe_state_e state_q, state_d;
  logic         state_en;

  // next-state: reads take priority; every direction change passes idle
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!rx_ready_n && !full) begin
          state_d = ST_RD_PRE;
        end else if (!tx_ready_n && !empty) begin
          state_d = ST_WR;
        end
      end
      ST_RD_PRE: begin
        state_d = rx_ready_n ? ST_IDLE : ST_RD_BURST;
      end
      ST_RD_BURST: begin
        // leave as the last free slot is taken, so rd_n never sits low on a full buffer
        if (rx_ready_n || last_free) state_d = ST_IDLE;
      end
      ST_WR: begin
        // a stalled byte stays at the head and is retried later
        if (tx_ready_n || last_item) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // Moore decode of the pin controls
  always_comb begin
    oe_n  = !((state_q == ST_RD_PRE) || (state_q == ST_RD_BURST));
    rd_n  = (state_q != ST_RD_BURST);
    wr_n  = (state_q != ST_WR);
    drive = (state_q == ST_WR);
    push  = (state_q == ST_RD_BURST) && !rx_ready_n;
    pop   = (state_q == ST_WR) && !tx_ready_n;
  end

endmodule

// File: rtl/usb_fifo_echo.sv
module usb_fifo_echo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_ready_n,
  input  logic          tx_ready_n,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_drive,
  output logic          oe_n,
  output logic          rd_n,
  output logic          wr_n
);

  localparam int LW = $clog2(DEPTH) + 1;

  logic          push, pop;
  logic          full, empty, last_free, last_item;
  logic [LW-1:0] fill_level;

  usbfe_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_ready_n (rx_ready_n),
    .tx_ready_n (tx_ready_n),
    .full       (full),
    .empty      (empty),
    .last_free  (last_free),
    .last_item  (last_item),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .oe_n       (oe_n),
    .drive      (data_drive),
    .push       (push),
    .pop        (pop)
  );

  usbfe_buffer #(
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .din       (data_i),
    .dout      (data_o),
    .full      (full),
    .empty     (empty),
    .last_free (last_free),
    .last_item (last_item),
    .level     (fill_level)
  );

endmodule

// File: rtl/usbfe_checker.sv
module usbfe_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rx_ready_n,
  input logic                   tx_ready_n,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic                   oe_n,
  input logic                   data_drive,
  input logic [DW-1:0]          data_o,
  input logic [$clog2(DEPTH):0] level
);

  localparam int LW = $clog2(DEPTH) + 1;

  AST_RESET_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (rd_n && wr_n && oe_n && !data_drive)); // R1
  AST_RD_NEEDS_OE:   assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !oe_n); // R2
  AST_OE_LEADS_RD:   assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_n) |-> $past(!oe_n)); // R2
  AST_PUSH_COUNT:    assert property (@(posedge clk) disable iff (!rst_n) (!rd_n && !rx_ready_n) |=> (level == $past(level) + 1'b1)); // R3
  AST_POP_COUNT:     assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && !tx_ready_n) |=> (level == $past(level) - 1'b1)); // R4
  AST_STALL_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && tx_ready_n) |=> $stable(data_o)); // R5
  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(data_drive && !oe_n)); // R6
  AST_DRIVE_GAP:     assert property (@(posedge clk) disable iff (!rst_n) $rose(data_drive) |-> $past(oe_n)); // R6
  AST_OE_GAP:        assert property (@(posedge clk) disable iff (!rst_n) $fell(oe_n) |-> $past(!data_drive)); // R6
  AST_NO_OVERFLOW:   assert property (@(posedge clk) disable iff (!rst_n) (!rd_n && !rx_ready_n) |-> (level != LW'(DEPTH))); // R7
  AST_WR_NONEMPTY:   assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> (level != '0)); // R8

endmodule

bind usb_fifo_echo usbfe_checker #(
  .DW    (DW),
  .DEPTH (DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_ready_n (rx_ready_n),
  .tx_ready_n (tx_ready_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .oe_n       (oe_n),
  .data_drive (data_drive),
  .data_o     (data_o),
  .level      (fill_level)
);

// File: tb/usb_fifo_echo_tb.sv
module usb_fifo_echo_tb;

  localparam int CLK_PERIOD = 4;

  typedef struct packed {
    logic [7:0] nbytes;
    logic [7:0] rx_gap;
    logic [7:0] tx_gap;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'd5,  8'h00, 8'h00},
    '{8'd40, 8'h00, 8'h00},
    '{8'd30, 8'h00, 8'hA6},
    '{8'd30, 8'h51, 8'h00},
    '{8'd50, 8'h30, 8'hC9},
    '{8'd1,  8'h00, 8'h00}
  };

  logic       clk;
  logic       rst_n;
  logic       rx_ready_n;
  logic       tx_ready_n;
  logic [7:0] data_i;
  logic [7:0] data_o;
  logic       data_drive;
  logic       oe_n;
  logic       rd_n;
  logic       wr_n;

  usb_fifo_echo u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_ready_n (rx_ready_n),
    .tx_ready_n (tx_ready_n),
    .data_i     (data_i),
    .data_o     (data_o),
    .data_drive (data_drive),
    .oe_n       (oe_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int mon_err = 0;
  int cyc = 0;

  // bridge model state
  logic [7:0] q   [64];
  logic [7:0] got [64];
  int q_n = 0, q_rd = 0, got_n = 0;
  logic [7:0] rx_mask = 8'h00, tx_mask = 8'h00;
  logic prev_oe_n = 1'b1, prev_drive = 1'b0, prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;

  function automatic logic [7:0] pat(int v, int i);
    return 8'((v * 37 + i * 11) ^ (i * 3 + 8'h5A));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle of the bridge: inspect outputs, then drive flags for the next edge
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (!rd_n && (oe_n || prev_oe_n)) begin
      mon_err++; $display("protocol violation R2 at cycle %0d", cyc);
    end
    if (data_drive && !oe_n) begin
      mon_err++; $display("protocol violation R6 overlap at cycle %0d", cyc);
    end
    if ((data_drive && !prev_drive && !prev_oe_n) || (!oe_n && prev_oe_n && prev_drive)) begin
      mon_err++; $display("protocol violation R6 turnaround at cycle %0d", cyc);
    end
    if (!wr_n && (q_rd - got_n) == 0) begin
      mon_err++; $display("protocol violation R8 at cycle %0d", cyc);
    end
    if (prev_stall && data_o != prev_data) begin
      mon_err++; $display("protocol violation R5 at cycle %0d", cyc);
    end
    rx_ready_n = (q_rd >= q_n) || rx_mask[3'(cyc)];
    data_i     = (q_rd < q_n) ? q[q_rd] : 8'h00;
    tx_ready_n = tx_mask[3'(cyc)];
    prev_stall = !wr_n && tx_ready_n;
    prev_data  = data_o;
    prev_oe_n  = oe_n;
    prev_drive = data_drive;
    if (!rd_n && !rx_ready_n) q_rd++;
    if (!wr_n && !tx_ready_n && got_n < 64) begin
      got[got_n] = data_o;
      got_n++;
    end
  endtask

  task automatic drain(input int n);
    for (int t = 0; t < 4000 && got_n < n; t++) tick();
  endtask

  task automatic compare_echo(input string tag, input int n);
    int bad = -1;
    check(got_n == n, "R10", {tag, " echo count"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++) begin
      if (bad < 0 && got[i] != q[i]) bad = i;
    end
    if (bad >= 0) check(1'b0, "R10", {tag, " echo byte"}, int'(got[bad]), int'(q[bad]));
    else          check(1'b1, "R10", {tag, " echo byte"}, 0, 0);
  endtask

  task automatic restart_model();
    q_n = 0; q_rd = 0; got_n = 0;
  endtask

  initial begin
    int m0;
    rst_n = 1'b0; rx_ready_n = 1'b1; tx_ready_n = 1'b0; data_i = 8'h00;
    repeat (3) @(negedge clk);
    check({rd_n, wr_n, oe_n, data_drive} == 4'b1110, "R1", "controls in reset",
          int'({rd_n, wr_n, oe_n, data_drive}), 14);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    check({rd_n, wr_n, oe_n, data_drive} == 4'b1110, "R1", "controls after reset, tx ready, empty",
          int'({rd_n, wr_n, oe_n, data_drive}), 14);

    // vector table: stream of bytes under rhythmic gaps, expect a clean echo (R3 R4 R5 R10)
    for (int v = 0; v < NVEC; v++) begin
      restart_model();
      for (int i = 0; i < int'(VECS[v].nbytes); i++) q[i] = pat(v, i);
      q_n = int'(VECS[v].nbytes);
      rx_mask = VECS[v].rx_gap;
      tx_mask = VECS[v].tx_gap;
      m0 = mon_err;
      drain(q_n);
      check(q_rd == q_n, "R3", $sformatf("vector %0d bytes read", v), q_rd, q_n);
      compare_echo($sformatf("vector %0d", v), q_n);
      check(mon_err == m0, "R2/R6", $sformatf("vector %0d pin protocol", v), mon_err - m0, 0);
    end

    // full buffer: writes stalled, more bytes offered than fit (R7)
    restart_model();
    rx_mask = 8'h00; tx_mask = 8'hFF;
    for (int i = 0; i < 20; i++) q[i] = pat(9, i);
    q_n = 20;
    for (int i = 0; i < 60; i++) tick();
    check(q_rd == 16, "R7", "bytes read into full buffer", q_rd, 16);
    check(rd_n && oe_n, "R7", "strobes idle while full", int'({rd_n, oe_n}), 3);
    tx_mask = 8'h00;
    drain(20);
    compare_echo("full-buffer", 20);

    // read wins over write when both become possible in the same idle cycle (R9)
    restart_model();
    tx_mask = 8'hFF;
    for (int i = 0; i < 5; i++) q[i] = pat(11, i);
    q_n = 3;
    for (int i = 0; i < 20; i++) tick();
    check(q_rd == 3, "R9", "parked bytes", q_rd, 3);
    q_n = 5; tx_mask = 8'h00;
    tick();
    tick();
    check(!oe_n && wr_n, "R9", "read chosen over write {oe_n,wr_n}", int'({oe_n, wr_n}), 1);
    drain(5);
    compare_echo("priority", 5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule